// File: doc/BRIEF.md
# Prioritized ECC Error Capture Register

This block keeps a log of error reports that come from a directory memory checker. There are four classes of event. Each class arrives as a one-cycle strobe, and each strobe comes with its own address, syndrome, bad protection value and protection sub-entry index. Every class has its own sticky valid bit. The detail fields, however, describe only the most serious class held in the log.

The detail fields change only when an incoming event outranks every class that is still valid. After software reads the log, it clears it by writing ones to the bits it wants to release. A clear that arrives in the same cycle as a new event takes effect first, and the new event is then recorded. No report is lost this way.

A second uncorrectable directory error that arrives before software releases the first one is marked by an overrun flag. A level interrupt stays high while any class is valid.

Top module: `ecc_err_log`

## Requirements
- R1: The valid vector has one bit per class, from highest to lowest priority: bit 3 is an uncorrectable directory error, bit 2 is a protection double-bit error, bit 1 is a correctable directory error and bit 0 is a protection correctable error. Event strobe bit k belongs to the class whose valid bit is k. The detail inputs for class k sit in slice k of each flattened detail bus.
- R2: Every strobed class sets its valid bit one clock later. A valid bit stays set until it is cleared or the block is reset.
- R3: Address, syndrome, protection value and index load from the highest strobed class when no valid bit is held, or when that class ranks above the highest held class. When several classes strobe together, all their valid bits are set.
- R4: An event whose highest class is equal to or below the highest held class leaves every detail field unchanged.
- R5: The overrun flag sets when an uncorrectable directory event arrives while valid bit 3 is set and is not being cleared in that cycle. The flag stays set until it is cleared.
- R6: A write with `clr_we` high clears each valid bit whose `clr_mask` bit (3:0) is one, and clears the overrun flag when `clr_mask` bit 4 is one. The detail fields are not changed by a clear.
- R7: When a clear and an event occur in the same cycle, the clear applies first. The event then sets its valid bit, and it loads the details if it outranks what remains.
- R8: `irq` is high exactly while any valid bit is set.
- R9: Reset sets all valid bits, the overrun flag, all detail fields and `irq` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 4 | One-cycle event strobes, one per class |
| ev_addr | input | 4*ADDR_W | Per-class failing entry address |
| ev_syn | input | 4*SYN_W | Per-class syndrome |
| ev_prot | input | 4*PROT_W | Per-class bad protection value |
| ev_pidx | input | 4*IDX_W | Per-class protection sub-entry index |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 5 | Bits to clear: 3:0 valid bits, 4 overrun |
| log_valid | output | 4 | Per-class valid bits |
| log_ovr | output | 1 | Uncorrectable overrun flag |
| log_addr | output | ADDR_W | Captured address |
| log_syn | output | SYN_W | Captured syndrome |
| log_prot | output | PROT_W | Captured protection value |
| log_pidx | output | IDX_W | Captured protection index |
| irq | output | 1 | Summary interrupt |

## Verification
The bench sweeps all 16 held valid patterns against all 16 incoming strobe patterns, building the held pattern with a first event after a full clear. This separates a detail load caused by a strictly higher class from a hold caused by an equal or lower class, and it covers the case where nothing is held. Each step carries detail values tagged with the step and the class, so a load taken from the wrong class or at the wrong time shows up as a wrong tag. Further sequences combine a clear with an event in the same cycle: a full release together with an uncorrectable event tells apart the R7 order from overrun marking, and a partial release tells apart a load against the remaining bits from a load against the bits held before the clear.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int NCLS = 4;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_PROT_CORR = 2'd0,
    CLS_DIR_CORR  = 2'd1,
    CLS_PROT_DBL  = 2'd2,
    CLS_DIR_UNC   = 2'd3
  } err_cls_e;

  // New event replaces details only when it strictly outranks the held set.
  function automatic logic outranks(input logic ev_any, input logic [CLS_W-1:0] ev_cls,
                                    input logic held_any, input logic [CLS_W-1:0] held_cls);
    return ev_any && (!held_any || (ev_cls > held_cls));
  endfunction
endpackage

// File: rtl/ecc_prio_pick.sv
module ecc_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  hit,
  output logic          any,
  output logic [IW-1:0] idx
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    if (i == N-1) begin : g_top
      assign hit[i] = req[i];
    end else begin : g_low
      assign hit[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) idx = IW'(i);
  end

  always_comb begin
    a_r3_single_winner: assert ($onehot0(hit));
    a_r3_winner_present: assert (any == (hit != '0));
  end
endmodule

// File: rtl/ecc_detail_mux.sv
module ecc_detail_mux #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] din,
  input  logic [IW-1:0]  sel,
  output logic [W-1:0]   dout
);
  logic [W-1:0] slice [N];
  for (genvar i = 0; i < N; i++) begin : g_slice
    assign slice[i] = din[i*W +: W];
  end
  assign dout = slice[sel];
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYN_W  = 8,
  parameter int PROT_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             ev_strobe,
  input  logic [4*ADDR_W-1:0]    ev_addr,
  input  logic [4*SYN_W-1:0]     ev_syn,
  input  logic [4*PROT_W-1:0]    ev_prot,
  input  logic [4*IDX_W-1:0]     ev_pidx,
  input  logic                   clr_we,
  input  logic [4:0]             clr_mask,
  output logic [3:0]             log_valid,
  output logic                   log_ovr,
  output logic [ADDR_W-1:0]      log_addr,
  output logic [SYN_W-1:0]       log_syn,
  output logic [PROT_W-1:0]      log_prot,
  output logic [IDX_W-1:0]       log_pidx,
  output logic                   irq
);
  localparam int DW = ADDR_W + SYN_W + PROT_W + IDX_W;

  // Pack each class's details into one record.
  logic [NCLS*DW-1:0] ev_rec;
  for (genvar c = 0; c < NCLS; c++) begin : g_pack
    assign ev_rec[c*DW +: DW] = {ev_addr[c*ADDR_W +: ADDR_W], ev_syn[c*SYN_W +: SYN_W],
                                 ev_prot[c*PROT_W +: PROT_W], ev_pidx[c*IDX_W +: IDX_W]};
  end

  // Named internal events.
  logic [3:0]       clr_valid_w;
  logic             clr_ovr_w;
  logic [3:0]       held_w;
  logic [3:0]       ev_hit_w, held_hit_w;
  logic             ev_any_w, held_any_w;
  logic [CLS_W-1:0] ev_cls_w, held_cls_w;
  logic             load_w;
  logic             ovr_hit_w;
  logic [DW-1:0]    win_rec_w;

  assign clr_valid_w = clr_we ? clr_mask[3:0] : 4'b0000;
  assign clr_ovr_w   = clr_we & clr_mask[4];
  assign held_w      = log_valid & ~clr_valid_w;

  ecc_prio_pick #(.N(NCLS)) u_ev_pick (
    .req(ev_strobe), .hit(ev_hit_w), .any(ev_any_w), .idx(ev_cls_w));
  ecc_prio_pick #(.N(NCLS)) u_held_pick (
    .req(held_w), .hit(held_hit_w), .any(held_any_w), .idx(held_cls_w));
  ecc_detail_mux #(.N(NCLS), .W(DW)) u_mux (
    .din(ev_rec), .sel(ev_cls_w), .dout(win_rec_w));

  assign load_w    = outranks(ev_any_w, ev_cls_w, held_any_w, held_cls_w);
  assign ovr_hit_w = ev_strobe[CLS_DIR_UNC] & held_w[CLS_DIR_UNC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_valid <= '0;
      log_ovr   <= 1'b0;
      log_addr  <= '0;
      log_syn   <= '0;
      log_prot  <= '0;
      log_pidx  <= '0;
    end else begin
      log_valid <= held_w | ev_strobe;
      log_ovr   <= (log_ovr & ~clr_ovr_w) | ovr_hit_w;
      if (load_w) {log_addr, log_syn, log_prot, log_pidx} <= win_rec_w;
    end
  end

  assign irq = |log_valid;

  // R2: every strobed class is valid next cycle
  a_r2_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_strobe != 4'b0) |=> ((log_valid & $past(ev_strobe)) == $past(ev_strobe)));
  // R3: loading takes the winning class's address
  a_r3_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (log_addr == $past(ev_addr[ev_cls_w*ADDR_W +: ADDR_W])));
  // R4: no load, details stable
  a_r4_hold_details: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> ($stable(log_addr) && $stable(log_syn) && $stable(log_prot) && $stable(log_pidx)));
  // R5: repeated uncorrectable error marks overrun
  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_strobe[3] && log_valid[3] && !(clr_we && clr_mask[3])) |=> log_ovr);
  // R6: cleared bits with no new event drop
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((log_valid & $past(clr_mask[3:0] & ~ev_strobe)) == 4'b0));
  // R8: interrupt follows any event
  a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_strobe != 4'b0) |=> irq);
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  localparam int AW = 16, SW = 8, PW = 4, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ev_strobe = '0;
  logic [4*AW-1:0] ev_addr = '0;
  logic [4*SW-1:0] ev_syn = '0;
  logic [4*PW-1:0] ev_prot = '0;
  logic [4*IW-1:0] ev_pidx = '0;
  logic clr_we = 1'b0;
  logic [4:0] clr_mask = '0;
  logic [3:0] log_valid;
  logic log_ovr, irq;
  logic [AW-1:0] log_addr;
  logic [SW-1:0] log_syn;
  logic [PW-1:0] log_prot;
  logic [IW-1:0] log_pidx;

  int checks = 0, errors = 0;

  // bench model
  logic [3:0] m_valid = '0;
  logic m_ovr = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [SW-1:0] m_syn = '0;
  logic [PW-1:0] m_prot = '0;
  logic [IW-1:0] m_pidx = '0;

  always #2.5ns clk = ~clk;

  ecc_err_log #(.ADDR_W(AW), .SYN_W(SW), .PROT_W(PW), .IDX_W(IW)) u_dut (
    .clk, .rst_n, .ev_strobe, .ev_addr, .ev_syn, .ev_prot, .ev_pidx, .clr_we, .clr_mask,
    .log_valid, .log_ovr, .log_addr, .log_syn, .log_prot, .log_pidx, .irq);

  function automatic logic [AW-1:0] t_addr(int s, int c); return AW'(s * 16 + c + 16'h4000); endfunction
  function automatic logic [SW-1:0] t_syn(int s, int c);  return SW'(s * 3 + c * 71 + 1); endfunction
  function automatic logic [PW-1:0] t_prot(int s, int c); return PW'(s + c * 5); endfunction
  function automatic logic [IW-1:0] t_pidx(int s, int c); return IW'(s + c); endfunction

  // rank: -1 if empty, else the position of the topmost one
  function automatic int rank(logic [3:0] v);
    int r = -1;
    for (int i = 3; i >= 0; i--) if (v[i] && r < 0) r = i;
    return r;
  endfunction

  task automatic cyc(input logic [3:0] ev, input logic cw, input logic [4:0] cm, input int s);
    logic [3:0] keep;
    int re;
    for (int c = 0; c < 4; c++) begin
      ev_addr[c*AW +: AW] = t_addr(s, c);
      ev_syn[c*SW +: SW]  = t_syn(s, c);
      ev_prot[c*PW +: PW] = t_prot(s, c);
      ev_pidx[c*IW +: IW] = t_pidx(s, c);
    end
    ev_strobe = ev; clr_we = cw; clr_mask = cm;
    keep = m_valid & ~(cw ? cm[3:0] : 4'b0);
    re = rank(ev);
    if (re >= 0 && re > rank(keep)) begin
      m_addr = t_addr(s, re); m_syn = t_syn(s, re); m_prot = t_prot(s, re); m_pidx = t_pidx(s, re);
    end
    m_ovr = (m_ovr & !(cw && cm[4])) | (ev[3] & keep[3]);
    m_valid = keep | ev;
    @(negedge clk);
    ev_strobe = '0; clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic check(input string req);
    checks++;
    if (log_valid !== m_valid || log_ovr !== m_ovr || log_addr !== m_addr || log_syn !== m_syn ||
        log_prot !== m_prot || log_pidx !== m_pidx || irq !== (m_valid != 0)) begin
      errors++;
      $display("FAIL %s: got v=%b o=%b a=%h s=%h p=%h i=%h irq=%b exp v=%b o=%b a=%h s=%h p=%h i=%h irq=%b",
               req, log_valid, log_ovr, log_addr, log_syn, log_prot, log_pidx, irq,
               m_valid, m_ovr, m_addr, m_syn, m_prot, m_pidx, m_valid != 0);
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s = 1;
    repeat (3) @(negedge clk);
    check("R9 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release");

    // R1 R2 R3 R4 R5: held pattern p against incoming pattern q
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        cyc(4'b0, 1'b1, 5'h1F, s); s++;
        check("R6 full clear");
        cyc(4'(p), 1'b0, 5'h00, s); s++;
        check("R2 R3 first event");
        cyc(4'(q), 1'b0, 5'h00, s); s++;
        check("R1 R3 R4 R5 R8 second event");
      end
    end

    // R6: release overrun only, valid stays
    cyc(4'b0, 1'b1, 5'h1F, s); s++;
    cyc(4'b1000, 1'b0, 5'h00, s); s++;
    cyc(4'b1000, 1'b0, 5'h00, s); s++;
    check("R5 overrun set");
    cyc(4'b0, 1'b1, 5'h10, s); s++;
    check("R6 overrun clear only");
    cyc(4'b0, 1'b1, 5'h08, s); s++;
    check("R6 R8 valid clear keeps details");

    // R7: full clear with uncorrectable event in same cycle
    cyc(4'b1100, 1'b0, 5'h00, s); s++;
    cyc(4'b1000, 1'b1, 5'h0F, s); s++;
    check("R7 clear plus event, no overrun, reload");

    // R7: partial clear, event outranks what remains
    cyc(4'b0, 1'b1, 5'h1F, s); s++;
    cyc(4'b1001, 1'b0, 5'h00, s); s++;
    cyc(4'b0010, 1'b1, 5'h08, s); s++;
    check("R7 partial clear then load");
    cyc(4'b0001, 1'b1, 5'h03, s); s++;
    check("R7 event survives own clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule